// File: doc/BRIEF.md
# Overcurrent and Short-Circuit Fault Qualifier

This block decides when the low-side current measurement of a buck converter has stayed high long enough to shut the converter down. An analog front end compares the sensed current against two levels, the overcurrent limit and twice that limit, and delivers both results as flags. A strobe marks the point, shortly after the low-side gate turns on in each PWM pulse, where those flags are valid. The block looks at the flags only on that strobe.

There are two qualification paths. For an overcurrent fault, every sampled pulse must stay above the limit for a whole time window. A single pulse below the limit restarts that window. The short-circuit path is faster. It fires after a set number of back-to-back pulses above twice the limit, or after a shorter time window, whichever ends first. Both windows count a microsecond tick that is divided down from the clock.

Once either fault is declared, it is held, and the block asks for converter latch-off. The fault stays until enable goes low or power-on reset is applied. The type of fault is reported as a 2-bit code.

Top module: `ocp_qualifier`

## Requirements
- R1: After power-on reset, fault_code is 00 and latch_off is 0.
- R2: A strobe with over_oc=1 arms the overcurrent window. If OC_US microsecond ticks then pass with no strobe carrying over_oc=0, fault_code becomes 01. The window is not met within (OC_US-1)*CLK_PER_US clock edges of the arming strobe's edge, and is always met within OC_US*CLK_PER_US edges of it.
- R3: A strobe with over_oc=0 disarms the overcurrent window. The window then restarts from zero at the next strobe with over_oc=1.
- R4: SC_PULSES consecutive strobes with over_sc=1 set fault_code to 10 on the clock edge of the last of those strobes.
- R5: A strobe with over_sc=0 clears the consecutive short-circuit count and the short-circuit window.
- R6: The first strobe with over_sc=1 arms a short-circuit window of SC_US ticks. The fault (code 10) is declared between (SC_US-1)*CLK_PER_US+1 and SC_US*CLK_PER_US edges after that strobe, even if fewer than SC_PULSES strobes arrive in that time.
- R7: A declared fault code is held while en stays high, whatever strobes and flags arrive afterwards, including a later short-circuit condition after an overcurrent fault.
- R8: With en=0, fault_code returns to 00 one edge later. While en stays 0, strobes are ignored and neither window runs.
- R9: rst_n low clears fault_code to 00 at once, without waiting for a clock edge.
- R10: over_oc and over_sc have no effect on any cycle where pulse_stb is 0.
- R11: latch_off is 1 exactly when fault_code is not 00. Code 11 is never produced. If both paths qualify on the same edge, the short-circuit code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| en | input | 1 | Converter enable; low clears the fault and holds the timers idle |
| pulse_stb | input | 1 | One-cycle strobe per PWM pulse when the sense flags are valid |
| over_oc | input | 1 | Sensed current is above the overcurrent limit |
| over_sc | input | 1 | Sensed current is above twice the overcurrent limit |
| fault_code | output | 2 | 00 none, 01 overcurrent, 10 short-circuit |
| latch_off | output | 1 | Request to hold the converter off |

## Verification
The assertions assume pulse_stb is a one-cycle pulse. They also assume over_sc is only raised together with over_oc, since a current above twice the limit is also above the limit. The bench drives every strobe as a single cycle and sets over_oc whenever it sets over_sc. Timing windows are checked against bounds one tick wide, because the microsecond tick runs freely and its phase relative to the arming strobe is not fixed. The bench samples just inside those bounds.

// File: rtl/ocq_pkg.sv
package ocq_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_OC   = 2'b01,
    FLT_SC   = 2'b10
  } flt_code_e;

  // Choose the fault code on the edge both paths are judged; short-circuit wins
  function automatic flt_code_e pick_code(input logic oc_done, input logic sc_done);
    if (sc_done)      return FLT_SC;
    else if (oc_done) return FLT_OC;
    else              return FLT_NONE;
  endfunction

  // Width large enough to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ocq_tick.sv
module ocq_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick
);
  localparam int PW = ocq_pkg::cnt_width(CLK_PER_US - 1);
  logic [PW-1:0] div_q;
  logic          wrap;

  assign wrap    = (div_q == PW'(CLK_PER_US - 1));
  assign us_tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (wrap) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  generate
    if (CLK_PER_US > 1) begin : g_spacing
      // R2: ticks are spaced apart, so a window cannot be met in back-to-back edges
      p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        us_tick |=> !us_tick);
    end
  endgenerate
endmodule

// File: rtl/ocq_oc_window.sv
module ocq_oc_window #(
  parameter int OC_US = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic us_tick,
  input  logic stb,
  input  logic over_oc,
  output logic oc_done,
  output logic oc_armed
);
  localparam int UW = ocq_pkg::cnt_width(OC_US);
  logic [UW-1:0] us_q;
  logic          armed_q;
  logic          stb_hi, stb_lo;

  assign stb_hi   = stb && over_oc && !hold;
  assign stb_lo   = stb && !over_oc && !hold;
  // a below-limit pulse on the last tick still cancels the window
  assign oc_done  = armed_q && us_tick && (us_q == UW'(OC_US - 1)) && !stb_lo && !hold;
  assign oc_armed = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      us_q    <= '0;
    end else if (hold || stb_lo || oc_done) begin
      armed_q <= 1'b0;
      us_q    <= '0;
    end else if (!armed_q) begin
      if (stb_hi) begin
        armed_q <= 1'b1;
        us_q    <= '0;
      end
    end else if (us_tick) begin
      us_q <= us_q + 1'b1;
    end
  end

  // R3: a pulse below the limit always drops the window
  p_low_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !over_oc && !hold) |=> !oc_armed);
  // R2: the window count never passes its length
  p_no_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
    us_q <= UW'(OC_US - 1));
endmodule

// File: rtl/ocq_sc_detect.sv
module ocq_sc_detect #(
  parameter int SC_US     = 10,
  parameter int SC_PULSES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic us_tick,
  input  logic stb,
  input  logic over_sc,
  output logic sc_done
);
  localparam int UW = ocq_pkg::cnt_width(SC_US);
  localparam int CW = ocq_pkg::cnt_width(SC_PULSES);
  logic [UW-1:0] us_q;
  logic [CW-1:0] run_q;
  logic          armed_q;
  logic          stb_hi, stb_lo, count_hit, time_hit;

  assign stb_hi    = stb && over_sc && !hold;
  assign stb_lo    = stb && !over_sc && !hold;
  assign count_hit = stb_hi && (run_q == CW'(SC_PULSES - 1));
  assign time_hit  = armed_q && us_tick && (us_q == UW'(SC_US - 1)) && !stb_lo && !hold;
  assign sc_done   = count_hit || time_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (hold || stb_lo || sc_done) begin
      run_q <= '0;
    end else if (stb_hi) begin
      run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      us_q    <= '0;
    end else if (hold || stb_lo || sc_done) begin
      armed_q <= 1'b0;
      us_q    <= '0;
    end else if (!armed_q) begin
      if (stb_hi) begin
        armed_q <= 1'b1;
        us_q    <= '0;
      end
    end else if (us_tick) begin
      us_q <= us_q + 1'b1;
    end
  end

  // R4: the run count stays below the pulse limit
  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(SC_PULSES));
  // R5: a pulse below twice the limit empties the run
  p_run_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !over_sc) |=> (run_q == '0));
endmodule

// File: rtl/ocq_fault_latch.sv
module ocq_fault_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       oc_done,
  input  logic       sc_done,
  output logic [1:0] code,
  output logic       latched
);
  import ocq_pkg::*;
  flt_code_e code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 code_q <= FLT_NONE;
    else if (!en)               code_q <= FLT_NONE;
    else if (code_q == FLT_NONE) code_q <= pick_code(oc_done, sc_done);
  end

  assign code    = code_q;
  assign latched = (code_q != FLT_NONE);

  // R7: a held fault does not change while enable stays high
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && latched) |=> $stable(code));
  // R8: enable low clears the fault on the next edge
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (code == 2'b00));
  // R11: the unused code is never produced
  p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    code != 2'b11);
endmodule

// File: rtl/ocp_qualifier.sv
module ocp_qualifier #(
  parameter int CLK_PER_US = 100,
  parameter int OC_US      = 20,
  parameter int SC_US      = 10,
  parameter int SC_PULSES  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pulse_stb,
  input  logic       over_oc,
  input  logic       over_sc,
  output logic [1:0] fault_code,
  output logic       latch_off
);
  logic us_tick;
  logic oc_done, oc_armed, sc_done;
  logic latched;
  logic hold;

  assign hold = !en || latched;

  ocq_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick));

  ocq_oc_window #(.OC_US(OC_US)) u_oc (
    .clk(clk), .rst_n(rst_n), .hold(hold), .us_tick(us_tick),
    .stb(pulse_stb), .over_oc(over_oc), .oc_done(oc_done), .oc_armed(oc_armed));

  ocq_sc_detect #(.SC_US(SC_US), .SC_PULSES(SC_PULSES)) u_sc (
    .clk(clk), .rst_n(rst_n), .hold(hold), .us_tick(us_tick),
    .stb(pulse_stb), .over_sc(over_sc), .sc_done(sc_done));

  ocq_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .en(en), .oc_done(oc_done), .sc_done(sc_done),
    .code(fault_code), .latched(latched));

  assign latch_off = latched;

  // R10: without a strobe the overcurrent window cannot arm
  p_no_strobe_no_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_armed && !pulse_stb) |=> !oc_armed);
  // R8: while enable is low nothing is held armed
  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !oc_armed);
  // R11: latch request follows the code
  p_latch_matches_r11: assert property (@(posedge clk) disable iff (!rst_n)
    latch_off == (fault_code != 2'b00));
endmodule

// File: tb/sim_ocp_qualifier.sv
module sim_ocp_qualifier;
  localparam int P  = 10;
  localparam int OW = 20;
  localparam int SW = 10;
  localparam int SN = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic pulse_stb = 1'b0, over_oc = 1'b0, over_sc = 1'b0;
  logic [1:0] fault_code;
  logic latch_off;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  ocp_qualifier #(.CLK_PER_US(P), .OC_US(OW), .SC_US(SW), .SC_PULSES(SN)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .pulse_stb(pulse_stb),
    .over_oc(over_oc), .over_sc(over_sc), .fault_code(fault_code), .latch_off(latch_off));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [1:0] exp);
    total++;
    if (fault_code !== exp || latch_off !== (exp != 2'b00)) begin
      bad++;
      $display("FAIL %s: code=%b latch=%b expected code=%b latch=%b",
               req, fault_code, latch_off, exp, (exp != 2'b00));
    end
  endtask

  // one clock cycle from negedge to negedge with given inputs
  task automatic cyc(input logic s, input logic oc, input logic sc);
    pulse_stb = s; over_oc = oc; over_sc = sc;
    @(negedge clk);
    pulse_stb = 1'b0;
  endtask

  task automatic train(input int n, input int per, input logic sc);
    for (int i = 0; i < n; i++) cyc(((i % per) == per - 1), 1'b1, sc);
  endtask

  task automatic clear_en();
    en = 1'b0; cyc(1'b0, 1'b0, 1'b0);
    en = 1'b1; cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 reset state", 2'b00);
  endtask

  task automatic t_oc_window();
    cyc(1'b1, 1'b1, 1'b0);
    train((OW - 1) * P - 1, 15, 1'b0);
    chk("R2 no overcurrent before window", 2'b00);
    train(P + 2, 15, 1'b0);
    chk("R2 overcurrent after window", 2'b01);
  endtask

  task automatic t_sticky_and_clear();
    train(20, 3, 1'b1);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R7 fault held after later strobes", 2'b01);
    en = 1'b0; cyc(1'b0, 1'b0, 1'b0);
    chk("R8 cleared by enable low", 2'b00);
    train(OW * P + 20, 4, 1'b1);
    chk("R8 strobes ignored while disabled", 2'b00);
    en = 1'b1; cyc(1'b0, 1'b0, 1'b0);
    chk("R8 stays clear on re-enable", 2'b00);
  endtask

  task automatic t_oc_restart();
    cyc(1'b1, 1'b1, 1'b0);
    train(150, 15, 1'b0);
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    train((OW - 1) * P - 1, 15, 1'b0);
    chk("R3 window restarted by low pulse", 2'b00);
    train(P + 2, 15, 1'b0);
    chk("R3 overcurrent after restarted window", 2'b01);
    clear_en();
  endtask

  task automatic t_sc_count();
    for (int i = 0; i < SN - 1; i++) cyc(1'b1, 1'b1, 1'b1);
    chk("R4 no short-circuit one pulse short", 2'b00);
    cyc(1'b1, 1'b1, 1'b1);
    chk("R4 short-circuit on last pulse", 2'b10);
    clear_en();
  endtask

  task automatic t_sc_break();
    for (int i = 0; i < SN - 1; i++) cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < SN - 1; i++) cyc(1'b1, 1'b1, 1'b1);
    chk("R5 run broken by lower pulse", 2'b00);
    cyc(1'b1, 1'b1, 1'b1);
    chk("R5 full run after break", 2'b10);
    clear_en();
  endtask

  task automatic t_sc_time();
    cyc(1'b1, 1'b1, 1'b1);
    train((SW - 1) * P - 2, 40, 1'b1);
    chk("R6 no short-circuit before window", 2'b00);
    for (int i = 0; i < P + 3; i++) cyc(1'b0, 1'b1, 1'b1);
    chk("R6 short-circuit by time", 2'b10);
    clear_en();
  endtask

  task automatic t_oc_then_sc();
    cyc(1'b1, 1'b1, 1'b0);
    train(OW * P + 2, 15, 1'b0);
    chk("R7 overcurrent latched", 2'b01);
    for (int i = 0; i < SN + 2; i++) cyc(1'b1, 1'b1, 1'b1);
    chk("R7 later short-circuit does not replace code", 2'b01);
    clear_en();
  endtask

  task automatic t_no_strobe();
    for (int i = 0; i < OW * P + 50; i++) cyc(1'b0, 1'b1, 1'b1);
    chk("R10 flags ignored without strobe", 2'b00);
  endtask

  task automatic t_por();
    for (int i = 0; i < SN; i++) cyc(1'b1, 1'b1, 1'b1);
    chk("R11 short-circuit code with latch", 2'b10);
    #2 rst_n = 1'b0;
    #1 chk("R9 asynchronous reset clear", 2'b00);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0);
    chk("R9 clear after reset release", 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0);
    t_reset();
    en = 1'b1;
    cyc(1'b0, 1'b0, 1'b0);
    t_oc_window();
    t_sticky_and_clear();
    t_oc_restart();
    t_sc_count();
    t_sc_break();
    t_sc_time();
    t_oc_then_sc();
    t_no_strobe();
    t_por();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule